// File: doc/BRIEF.md
# Packed String Compare Unit

This unit takes two 128-bit packed character operands, a reference string and a source string, and compares every source element with every reference element in a single operation. It supports sixteen 8-bit or eight 16-bit characters. An 8-bit control word picks the character size, signed or unsigned range bounds, one of four aggregation modes, a polarity treatment and the output shape. It is meant for text-scanning engines that need set membership, character-class tests, element-wise equality or substring search on a 16-byte window in one step.

Each operand's length is either given explicitly or taken from its first all-zero element. The aggregated per-element result is returned both as a match index (first or last) and as a match mask (compact or expanded to full elements), together with four status flags. Results are registered once: the outputs belong to the operation accepted one clock earlier.

Top module: `psc_unit`

## Requirements
- R1: Control bit 0 set selects eight 16-bit elements (element k at bits 16k+15:16k); clear selects sixteen 8-bit elements (element k at bits 8k+7:8k).
- R2: When explicit_i is high, each operand's valid length is its length input saturated to the element count; when low, it is the index of the first all-zero element, or the element count if there is none.
- R3: Mode 00 (control bits 3:2): source element j matches when it is valid and equals some valid reference element.
- R4: Mode 01: reference elements form pairs, lower bound in slot 2k and upper bound in slot 2k+1; a valid source element matches when lower <= element <= upper for a pair whose both slots are valid; control bit 1 makes the compare signed.
- R5: Mode 10: element i matches when both are valid and equal, or when both are invalid; a valid/invalid mix does not match.
- R6: Mode 11: position j matches when for every reference index i with i+j below the count, either reference element i is invalid, or source element i+j is valid and equal to it.
- R7: Control bits 5:4 set polarity: 01 inverts every result bit, 11 inverts only the bits below the source length, 00 and 10 leave the result unchanged.
- R8: idx_o gives the lowest set result bit when control bit 6 is clear, the highest when set, and the element count (16 or 8) when no bit is set.
- R9: With control bit 6 clear, mask_o holds the result bits zero-extended; with it set, each result bit fills its whole element.
- R10: cf_o is high when any result bit is set; of_o equals result bit 0.
- R11: zf_o is high when the source length is below the element count; sf_o is the same for the reference length.
- R12: valid_o follows valid_i by one cycle; results update only for accepted operations and hold otherwise; reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation accepted this cycle |
| ctrl_i | input | 8 | Control word |
| ref_i | input | 128 | Reference string |
| src_i | input | 128 | Source string |
| explicit_i | input | 1 | Use explicit lengths instead of null detection |
| len_ref_i | input | 5 | Explicit reference length |
| len_src_i | input | 5 | Explicit source length |
| valid_o | output | 1 | Result valid |
| idx_o | output | 5 | Match index |
| mask_o | output | 128 | Match mask |
| cf_o | output | 1 | Result nonzero |
| zf_o | output | 1 | Source shorter than element count |
| sf_o | output | 1 | Reference shorter than element count |
| of_o | output | 1 | Result bit 0 |

## Verification
The bench builds the unit at its default 128-bit operand width, so both the sixteen-byte lane and the eight-word lane are live and the no-match index differs between them (16 versus 8). That width also brings the saturation of a 5-bit explicit length above the element count, the partial substring at the end of the window, word-sized null detection where one byte of a word is zero, and signed range bounds on bytes into reach with hand-computed expected results.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic [1:0] {
    MODE_ANY   = 2'b00,
    MODE_RANGE = 2'b01,
    MODE_EACH  = 2'b10,
    MODE_ORD   = 2'b11
  } mode_e;

  typedef struct packed {
    logic       rsv;
    logic       last;
    logic [1:0] pol;
    mode_e      mode;
    logic       sgn;
    logic       word;
  } ctrl_t;
endpackage

// File: rtl/psc_len.sv
module psc_len #(
  parameter int DATA_W = 128,
  parameter int EW     = 8,
  parameter int LW     = 5,
  localparam int N     = DATA_W / EW,
  localparam int CW    = $clog2(N) + 1
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              explicit_i,
  input  logic [LW-1:0]     len_i,
  output logic [CW-1:0]     len_o,
  output logic              short_o
);
  logic [CW-1:0] null_pos;

  always_comb begin
    null_pos = CW'(N);
    for (int k = N - 1; k >= 0; k--) begin
      if (data_i[k*EW +: EW] == '0) null_pos = CW'(k);
    end
  end

  always_comb begin
    if (explicit_i) len_o = (len_i >= LW'(N)) ? CW'(N) : CW'(len_i);
    else            len_o = null_pos;
  end

  assign short_o = (len_o < CW'(N));
endmodule

// File: rtl/psc_lane.sv
module psc_lane
  import psc_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int EW     = 8,
  parameter int LW     = 5,
  localparam int N     = DATA_W / EW,
  localparam int CW    = $clog2(N) + 1
) (
  input  logic [DATA_W-1:0] ref_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic              explicit_i,
  input  logic [LW-1:0]     len_ref_i,
  input  logic [LW-1:0]     len_src_i,
  input  mode_e             mode_i,
  input  logic              sgn_i,
  input  logic [1:0]        pol_i,
  output logic [N-1:0]      res_o,
  output logic              ref_short_o,
  output logic              src_short_o
);
  logic [CW-1:0] la, lb;
  logic [EW-1:0] ae [N];
  logic [EW-1:0] be [N];
  logic [N-1:0]  raw;

  psc_len #(.DATA_W(DATA_W), .EW(EW), .LW(LW)) u_len_ref (
    .data_i(ref_i), .explicit_i(explicit_i), .len_i(len_ref_i),
    .len_o(la), .short_o(ref_short_o)
  );
  psc_len #(.DATA_W(DATA_W), .EW(EW), .LW(LW)) u_len_src (
    .data_i(src_i), .explicit_i(explicit_i), .len_i(len_src_i),
    .len_o(lb), .short_o(src_short_o)
  );

  for (genvar k = 0; k < N; k++) begin : g_elem
    assign ae[k] = ref_i[k*EW +: EW];
    assign be[k] = src_i[k*EW +: EW];
  end

  function automatic logic le_f(input logic [EW-1:0] x, input logic [EW-1:0] y, input logic s);
    le_f = s ? ($signed(x) <= $signed(y)) : (x <= y);
  endfunction

  always_comb begin
    logic m;
    raw = '0;
    m   = 1'b0;
    case (mode_i)
      MODE_ANY: begin
        for (int j = 0; j < N; j++)
          for (int i = 0; i < N; i++)
            if (CW'(i) < la && CW'(j) < lb && ae[i] == be[j]) raw[j] = 1'b1;
      end
      MODE_RANGE: begin
        for (int j = 0; j < N; j++)
          for (int k = 0; k < N / 2; k++)
            if (CW'(2*k+1) < la && CW'(j) < lb &&
                le_f(ae[2*k], be[j], sgn_i) && le_f(be[j], ae[2*k+1], sgn_i))
              raw[j] = 1'b1;
      end
      MODE_EACH: begin
        for (int i = 0; i < N; i++) begin
          if (CW'(i) < la && CW'(i) < lb) raw[i] = (ae[i] == be[i]);
          else if (CW'(i) >= la && CW'(i) >= lb) raw[i] = 1'b1;
        end
      end
      MODE_ORD: begin
        for (int j = 0; j < N; j++) begin
          m = 1'b1;
          for (int i = 0; i < N; i++) begin
            if (i + j < N && CW'(i) < la) begin
              if (CW'(i + j) >= lb) m = 1'b0;
              else if (ae[i] != be[i+j]) m = 1'b0;
            end
          end
          raw[j] = m;
        end
      end
    endcase
  end

  // polarity: 01 invert all, 11 invert source-valid positions only
  always_comb begin
    case (pol_i)
      2'b01: res_o = ~raw;
      2'b11: for (int j = 0; j < N; j++) res_o[j] = (CW'(j) < lb) ? ~raw[j] : raw[j];
      default: res_o = raw;
    endcase
  end
endmodule

// File: rtl/psc_result.sv
module psc_result #(
  parameter int DATA_W = 128,
  localparam int NB    = DATA_W / 8,
  localparam int NW    = DATA_W / 16,
  localparam int LW    = $clog2(NB) + 1
) (
  input  logic [NB-1:0]     res_i,
  input  logic              word_i,
  input  logic              last_i,
  output logic [LW-1:0]     idx_o,
  output logic [DATA_W-1:0] mask_o
);
  always_comb begin
    idx_o = word_i ? LW'(NW) : LW'(NB);
    if (last_i) begin
      for (int k = 0; k < NB; k++) if (res_i[k]) idx_o = LW'(k);
    end else begin
      for (int k = NB - 1; k >= 0; k--) if (res_i[k]) idx_o = LW'(k);
    end
  end

  always_comb begin
    mask_o = '0;
    if (!last_i)     mask_o = DATA_W'(res_i);
    else if (word_i) for (int k = 0; k < NW; k++) mask_o[k*16 +: 16] = {16{res_i[k]}};
    else             for (int k = 0; k < NB; k++) mask_o[k*8 +: 8]   = {8{res_i[k]}};
  end
endmodule

// File: rtl/psc_unit.sv
module psc_unit
  import psc_pkg::*;
#(
  parameter int DATA_W = 128,
  localparam int NB    = DATA_W / 8,
  localparam int NW    = DATA_W / 16,
  localparam int LW    = $clog2(NB) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        ctrl_i,
  input  logic [DATA_W-1:0] ref_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic              explicit_i,
  input  logic [LW-1:0]     len_ref_i,
  input  logic [LW-1:0]     len_src_i,
  output logic              valid_o,
  output logic [LW-1:0]     idx_o,
  output logic [DATA_W-1:0] mask_o,
  output logic              cf_o,
  output logic              zf_o,
  output logic              sf_o,
  output logic              of_o
);
  ctrl_t         c;
  logic [NB-1:0] res_b, res;
  logic [NW-1:0] res_w;
  logic          rs_b, ss_b, rs_w, ss_w;
  logic [LW-1:0]     idx_n;
  logic [DATA_W-1:0] mask_n;
  logic          unused_rsv;

  assign c          = ctrl_t'(ctrl_i);
  assign unused_rsv = c.rsv;

  psc_lane #(.DATA_W(DATA_W), .EW(8), .LW(LW)) u_lane_b (
    .ref_i(ref_i), .src_i(src_i), .explicit_i(explicit_i),
    .len_ref_i(len_ref_i), .len_src_i(len_src_i),
    .mode_i(c.mode), .sgn_i(c.sgn), .pol_i(c.pol),
    .res_o(res_b), .ref_short_o(rs_b), .src_short_o(ss_b)
  );

  psc_lane #(.DATA_W(DATA_W), .EW(16), .LW(LW)) u_lane_w (
    .ref_i(ref_i), .src_i(src_i), .explicit_i(explicit_i),
    .len_ref_i(len_ref_i), .len_src_i(len_src_i),
    .mode_i(c.mode), .sgn_i(c.sgn), .pol_i(c.pol),
    .res_o(res_w), .ref_short_o(rs_w), .src_short_o(ss_w)
  );

  assign res = c.word ? {{(NB-NW){1'b0}}, res_w} : res_b;

  psc_result #(.DATA_W(DATA_W)) u_result (
    .res_i(res), .word_i(c.word), .last_i(c.last),
    .idx_o(idx_n), .mask_o(mask_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      idx_o   <= '0;
      mask_o  <= '0;
      cf_o    <= 1'b0;
      zf_o    <= 1'b0;
      sf_o    <= 1'b0;
      of_o    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        idx_o  <= idx_n;
        mask_o <= mask_n;
        cf_o   <= |res;
        of_o   <= res[0];
        zf_o   <= c.word ? ss_w : ss_b;
        sf_o   <= c.word ? rs_w : rs_b;
      end
    end
  end
endmodule

// File: rtl/psc_unit_chk.sv
module psc_unit_chk #(
  parameter int DATA_W = 128,
  localparam int NB    = DATA_W / 8,
  localparam int NW    = DATA_W / 16,
  localparam int LW    = $clog2(NB) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              word_i,
  input logic              last_i,
  input logic              explicit_i,
  input logic [LW-1:0]     len_src_i,
  input logic              valid_o,
  input logic [LW-1:0]     idx_o,
  input logic [DATA_W-1:0] mask_o,
  input logic              cf_o,
  input logic              zf_o,
  input logic              of_o
);
  AST_VALID_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R12
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R12
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(mask_o) && $stable(idx_o))); // R12
  AST_CARRY_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cf_o == (|mask_o))); // R10
  AST_OVFL_BIT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (of_o == mask_o[0])); // R10
  AST_NOMATCH_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !cf_o) |-> (idx_o == ($past(word_i) ? LW'(NW) : LW'(NB)))); // R8
  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(explicit_i)) |->
      (zf_o == ($past(len_src_i) < ($past(word_i) ? LW'(NW) : LW'(NB))))); // R11
  AST_MASK_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(last_i) && $past(word_i)) |-> (mask_o[DATA_W-1:NW] == '0)); // R9
endmodule

bind psc_unit psc_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
  .word_i(ctrl_i[0]), .last_i(ctrl_i[6]), .explicit_i(explicit_i),
  .len_src_i(len_src_i), .valid_o(valid_o), .idx_o(idx_o), .mask_o(mask_o),
  .cf_o(cf_o), .zf_o(zf_o), .of_o(of_o)
);

// File: tb/psc_unit_tb.sv
`timescale 1ns/1ps
module psc_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [7:0]   ctrl = '0;
  logic [127:0] ref_d = '0, src_d = '0;
  logic         expl = 1'b0;
  logic [4:0]   lr = '0, ls = '0;
  logic         valid_o, cf, zf, sf, of;
  logic [4:0]   idx;
  logic [127:0] mask;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  psc_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .ctrl_i(ctrl),
    .ref_i(ref_d), .src_i(src_d), .explicit_i(expl),
    .len_ref_i(lr), .len_src_i(ls), .valid_o(valid_o), .idx_o(idx),
    .mask_o(mask), .cf_o(cf), .zf_o(zf), .sf_o(sf), .of_o(of)
  );

  function automatic logic [127:0] s8(input string s);
    logic [127:0] r = '0;
    for (int k = 0; k < s.len() && k < 16; k++) r[k*8 +: 8] = s[k];
    return r;
  endfunction

  task automatic chk(input string req, input string what, input logic [127:0] got, input logic [127:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic op(input logic [7:0] c, input logic [127:0] r, input logic [127:0] s,
                    input logic e, input logic [4:0] l_r, input logic [4:0] l_s);
    @(negedge clk);
    ctrl = c; ref_d = r; src_d = s; expl = e; lr = l_r; ls = l_s; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    chk("R12", "valid_o", 128'(valid_o), 128'd1);
  endtask

  task automatic t_reset;
    chk("R12", "reset valid", 128'(valid_o), 128'd0);
    chk("R12", "reset idx", 128'(idx), 128'd0);
    chk("R12", "reset mask", mask, 128'd0);
  endtask

  task automatic t_equal_any;
    op(8'h00, s8("ae"), s8("xayze"), 1'b0, 5'd0, 5'd0);
    chk("R3", "any mask", mask, 128'h12);
    chk("R8", "first idx", 128'(idx), 128'd1);
    chk("R10", "cf", 128'(cf), 128'd1);
    chk("R10", "of", 128'(of), 128'd0);
    chk("R11", "zf", 128'(zf), 128'd1);
    chk("R11", "sf", 128'(sf), 128'd1);
    op(8'h40, s8("ae"), s8("xayze"), 1'b0, 5'd0, 5'd0);
    chk("R8", "last idx", 128'(idx), 128'd4);
    chk("R9", "expanded bytes", mask, 128'hFF_0000_FF00);
  endtask

  task automatic t_ranges;
    op(8'h04, s8("az"), s8("Hi5q"), 1'b0, 5'd0, 5'd0);
    chk("R4", "range mask", mask, 128'hA);
    op(8'h06, 128'h10F0, 128'hF8_80_05, 1'b1, 5'd2, 5'd3);
    chk("R4", "signed range", mask, 128'h5);
    op(8'h04, 128'h10F0, 128'hF8_80_05, 1'b1, 5'd2, 5'd3);
    chk("R4", "unsigned range", mask, 128'h0);
    chk("R8", "no match idx bytes", 128'(idx), 128'd16);
    chk("R10", "cf clear", 128'(cf), 128'd0);
  endtask

  task automatic t_equal_each;
    op(8'h08, s8("abd"), s8("abcde"), 1'b1, 5'd3, 5'd5);
    chk("R5", "each mask", mask, 128'hFFE3);
    chk("R10", "of set", 128'(of), 128'd1);
    chk("R11", "zf explicit", 128'(zf), 128'd1);
    op(8'h18, s8("abd"), s8("abcde"), 1'b1, 5'd3, 5'd5);
    chk("R7", "invert all", mask, 128'h001C);
    chk("R8", "idx after invert", 128'(idx), 128'd2);
    op(8'h38, s8("abd"), s8("abcde"), 1'b1, 5'd3, 5'd5);
    chk("R7", "invert valid", mask, 128'hFFFC);
    op(8'h28, s8("abd"), s8("abcde"), 1'b1, 5'd3, 5'd5);
    chk("R7", "pol 10 plain", mask, 128'hFFE3);
  endtask

  task automatic t_saturate;
    op(8'h48, s8("0123456789abcdef"), s8("0123456789abcdef"), 1'b1, 5'd31, 5'd31);
    chk("R2", "saturated mask", mask, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF);
    chk("R11", "zf saturated", 128'(zf), 128'd0);
    chk("R11", "sf saturated", 128'(sf), 128'd0);
    chk("R8", "last idx 15", 128'(idx), 128'd15);
    op(8'h00, s8("f"), s8("0123456789abcdef"), 1'b0, 5'd0, 5'd0);
    chk("R2", "implicit full zf", 128'(zf), 128'd0);
    chk("R3", "any at 15", mask, 128'h8000);
  endtask

  task automatic t_ordered;
    op(8'h0C, s8("ab"), s8("xabyab"), 1'b0, 5'd0, 5'd0);
    chk("R6", "ordered mask", mask, 128'h12);
    op(8'h0C, s8("ab"), s8("xxa"), 1'b0, 5'd0, 5'd0);
    chk("R6", "tail partial", mask, 128'h0);
    op(8'h0C, s8("zz"), s8("abc"), 1'b1, 5'd0, 5'd3);
    chk("R6", "empty ref", mask, 128'hFFFF);
    chk("R11", "sf empty ref", 128'(sf), 128'd1);
  endtask

  task automatic t_words;
    op(8'h01, 128'h5678_1234, 128'h1234_0034_5678, 1'b1, 5'd2, 5'd3);
    chk("R1", "word any mask", mask, 128'h5);
    chk("R8", "word first idx", 128'(idx), 128'd0);
    op(8'h41, 128'h5678_1234, 128'h1234_0034_5678, 1'b1, 5'd2, 5'd3);
    chk("R8", "word last idx", 128'(idx), 128'd2);
    chk("R9", "expanded words", mask, 128'h0000_FFFF_0000_FFFF);
    op(8'h01, 128'h0100, 128'h0100, 1'b0, 5'd0, 5'd0);
    chk("R2", "word null", mask, 128'h1);
    chk("R11", "word zf", 128'(zf), 128'd1);
    op(8'h01, 128'h7777, 128'h0100, 1'b0, 5'd0, 5'd0);
    chk("R8", "no match idx words", 128'(idx), 128'd8);
  endtask

  task automatic t_hold;
    @(negedge clk);
    ctrl = 8'h00; ref_d = s8("q"); src_d = s8("qqqq"); expl = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R12", "idle valid", 128'(valid_o), 128'd0);
    chk("R12", "held idx", 128'(idx), 128'd8);
    chk("R12", "held mask", mask, 128'h0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R12 watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_equal_any();
    t_ranges();
    t_equal_each();
    t_saturate();
    t_ordered();
    t_words();
    t_hold();
    finish_run();
  end
endmodule